// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog built on a down-counter that reloads from a programmed preload value. Before it is started, software programs three settings through a small register-style write port: the preload, a window code and a reaction code. A start pulse then loads the counter, and from that point the watchdog runs until the block is reset. It cannot be stopped, and every setting is frozen.

Software keeps the watchdog alive by writing a two-word key sequence to the key port. When the window code selects a fraction below 100%, a service is accepted only while the counter is in the final part of its countdown. A service that arrives earlier is a violation. If the counter reaches zero and a further cycle passes with no service, that is also a violation. A violation raises either a reset request or a non-maskable interrupt request, as chosen by the reaction code, together with a sticky flag that names the cause.

The controller is a three-state machine. The states are IDLE (configurable, stopped), RUN (counting, locked) and TRIP (violation latched). Its transitions are:
- `start` (IDLE to RUN, only with a nonzero preload)
- `serviced` (RUN to RUN with reload)
- `early` (RUN to TRIP on a service outside the window)
- `expired` (RUN to TRIP on underflow)

TRIP is left only through reset.

Top module: `wwdt_top`

## Requirements
- R1: After reset, `rst_req`, `nmi_req`, `running`, `early_flag` and `expire_flag` are all 0 and `count` is 0. The reaction code resets to 0x5 and the window code resets to the full-window code.
- R2: A `start` pulse in IDLE with a nonzero preload moves to RUN and loads `count` with the preload at that edge. A `start` with a zero preload is ignored and the block stays in IDLE.
- R3: In RUN with no service, `count` falls by one per clock. At the first edge where `count` is already 0, the block enters TRIP with `expire_flag` set. This is the edge P+1 edges after the start edge.
- R4: A service is a key write of 0xE51A, followed by a key write of 0xA35C as the next key write; idle cycles in between are allowed. A service inside the window reloads `count` with the preload at the edge of the second write. Any other second word cancels the sequence and is not a service.
- R5: The window code selects the window. 0x00000005 gives the full window, 100%, where a service is accepted at any count. The fractional codes are 0x00000050 for 1/2, 0x00000500 for 1/4, 0x00005000 for 1/8, 0x00050000 for 1/16 and 0x00500000 for 1/32. Any other code gives 1/32. The window is open while `count` is at or below the preload shifted right by the fraction's exponent.
- R6: A service while `count` is above the window threshold enters TRIP with `early_flag` set and no reload.
- R7: On a violation, reaction code 0xA raises `nmi_req` and not `rst_req`. Code 0x5, and every other code, raises `rst_req` and not `nmi_req`.
- R8: While running, writes to preload, window code and reaction code are ignored, and `start` has no further effect.
- R9: In TRIP, `rst_req`/`nmi_req` and the violation flags stay set until reset, and key writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 preload, 1 window code, 2 reaction code |
| cfg_wdata | input | 32 | Configuration write data |
| key_we | input | 1 | Key write strobe |
| key_data | input | 16 | Key word |
| start | input | 1 | Start pulse |
| running | output | 1 | High when out of IDLE |
| count | output | 32 | Current counter value |
| rst_req | output | 1 | Reset request, sticky |
| nmi_req | output | 1 | Non-maskable interrupt request, sticky |
| early_flag | output | 1 | Sticky: service outside the window |
| expire_flag | output | 1 | Sticky: counter expired |

## Verification
The hardest case to reach from the ports is a service whose second key word lands exactly on the window threshold, or one count above it. Reaching it requires counting every edge from the start pulse through both key writes. The bench computes the counter value at the deciding edge from the number of idle cycles it inserted. It places directed services at the threshold and at the threshold plus one. It then sweeps random preloads, window codes (including an unlisted one) and service times with a fixed seed.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;
    localparam int SHW    = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2
    } wd_state_t;

    localparam logic [KEY_W-1:0]  KEY_OPEN  = 16'hE51A;
    localparam logic [KEY_W-1:0]  KEY_SEAL  = 16'hA35C;
    localparam logic [3:0]        RXN_RESET = 4'h5;
    localparam logic [3:0]        RXN_NMI   = 4'hA;
    localparam logic [DATA_W-1:0] WIN_FULL  = 32'h0000_0005;

    localparam logic [1:0] SEL_PRELOAD = 2'd0;
    localparam logic [1:0] SEL_WINDOW  = 2'd1;
    localparam logic [1:0] SEL_REACT   = 2'd2;

    // window code -> right-shift amount applied to the preload
    function automatic logic [SHW-1:0] win_shift(input logic [DATA_W-1:0] code);
        case (code)
            WIN_FULL:     return 3'd0;
            32'h0000_0050: return 3'd1;
            32'h0000_0500: return 3'd2;
            32'h0000_5000: return 3'd3;
            32'h0005_0000: return 3'd4;
            default:      return 3'd5;
        endcase
    endfunction
endpackage

// File: rtl/wwdt_cfg.sv
module wwdt_cfg
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [CNT_W-1:0]     preload_o,
    output logic [SHW-1:0]       shift_o,
    output logic                 nmi_sel_o
);
    logic [3:0] react_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_o <= '0;
            shift_o   <= '0;
            react_q   <= RXN_RESET;
        end else if (cfg_we && !lock) begin
            unique case (cfg_sel)
                SEL_PRELOAD: preload_o <= cfg_wdata[CNT_W-1:0];
                SEL_WINDOW:  shift_o   <= win_shift(cfg_wdata);
                SEL_REACT:   react_q   <= cfg_wdata[3:0];
                default:     ;
            endcase
        end
    end

    assign nmi_sel_o = (react_q == RXN_NMI);

    p_cfg_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(preload_o) && $stable(shift_o) && $stable(react_q)));
endmodule

// File: rtl/wwdt_key.sv
module wwdt_key
    import wwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_data,
    output logic             svc_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            armed_q <= 1'b0;
        else if (key_we)
            armed_q <= !armed_q && (key_data == KEY_OPEN);
    end

    assign svc_o = enable && key_we && armed_q && (key_data == KEY_SEAL);
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             svc,
    input  logic [CNT_W-1:0] preload,
    input  logic [SHW-1:0]   shift,
    input  logic             nmi_sel,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             tripped_o,
    output logic             rst_req_o,
    output logic             nmi_req_o,
    output logic             early_o,
    output logic             expire_o
);
    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] thresh;
    logic             win_open, early_d, exp_d;

    assign thresh   = preload >> shift;
    assign win_open = (count_o <= thresh);

    always_comb begin
        state_d = state_q;
        cnt_d   = count_o;
        early_d = 1'b0;
        exp_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (preload != '0)) begin
                    state_d = ST_RUN;
                    cnt_d   = preload;
                end
            end
            ST_RUN: begin
                if (svc) begin
                    if (win_open) begin
                        cnt_d = preload;
                    end else begin
                        state_d = ST_TRIP;
                        early_d = 1'b1;
                    end
                end else if (count_o == '0) begin
                    state_d = ST_TRIP;
                    exp_d   = 1'b1;
                end else begin
                    cnt_d = count_o - 1'b1;
                end
            end
            ST_TRIP: ;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_o <= '0;
        end else begin
            state_q <= state_d;
            count_o <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_o <= 1'b0;
            nmi_req_o <= 1'b0;
            early_o   <= 1'b0;
            expire_o  <= 1'b0;
        end else begin
            rst_req_o <= rst_req_o | ((early_d | exp_d) & !nmi_sel);
            nmi_req_o <= nmi_req_o | ((early_d | exp_d) &  nmi_sel);
            early_o   <= early_o | early_d;
            expire_o  <= expire_o | exp_d;
        end
    end

    assign running_o = (state_q != ST_IDLE);
    assign tripped_o = (state_q == ST_TRIP);

    p_one_reaction_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && nmi_req_o));
    p_trip_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tripped_o |=> (tripped_o && $stable(rst_req_o) && $stable(nmi_req_o)));
    p_zero_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && preload == '0) |=> (state_q == ST_IDLE));
    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !svc && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && svc && win_open) |=> (count_o == $past(preload) && !tripped_o));
    p_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && svc && !win_open) |=> (tripped_o && early_o));
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              key_we,
    input  logic [15:0]       key_data,
    input  logic              start,
    output logic              running,
    output logic [CNT_W-1:0]  count,
    output logic              rst_req,
    output logic              nmi_req,
    output logic              early_flag,
    output logic              expire_flag
);
    logic [CNT_W-1:0] preload;
    logic [SHW-1:0]   shift;
    logic             nmi_sel, svc, tripped;

    wwdt_cfg #(.CNT_W(CNT_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .lock(running),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .preload_o(preload), .shift_o(shift), .nmi_sel_o(nmi_sel)
    );

    wwdt_key i_key (
        .clk(clk), .rst_n(rst_n), .enable(running && !tripped),
        .key_we(key_we), .key_data(key_data), .svc_o(svc)
    );

    wwdt_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .start(start), .svc(svc),
        .preload(preload), .shift(shift), .nmi_sel(nmi_sel),
        .count_o(count), .running_o(running), .tripped_o(tripped),
        .rst_req_o(rst_req), .nmi_req_o(nmi_req),
        .early_o(early_flag), .expire_o(expire_flag)
    );
endmodule

// File: tb/test_wwdt_top.sv
module test_wwdt_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        key_we;
    logic [15:0] key_data;
    logic        start;
    logic        running, rst_req, nmi_req, early_flag, expire_flag;
    logic [31:0] count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wwdt_top i_wwdt_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .key_we(key_we), .key_data(key_data),
        .start(start), .running(running), .count(count),
        .rst_req(rst_req), .nmi_req(nmi_req),
        .early_flag(early_flag), .expire_flag(expire_flag)
    );

    function automatic int exp_shift(input logic [31:0] code);
        if (code == 32'h5)        return 0;
        if (code == 32'h50)       return 1;
        if (code == 32'h500)      return 2;
        if (code == 32'h5000)     return 3;
        if (code == 32'h50000)    return 4;
        return 5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 0; key_we = 0; start = 0;
        cfg_sel = 0; cfg_wdata = 0; key_data = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic key_write(input logic [15:0] d);
        key_we = 1; key_data = d;
        @(negedge clk);
        key_we = 0;
    endtask

    task automatic pulse_start();
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic outcome(input string req, input bit trip_exp, input bit nmi_exp);
        chk(req, {31'd0, rst_req}, {31'd0, trip_exp && !nmi_exp});
        chk(req, {31'd0, nmi_req}, {31'd0, trip_exp && nmi_exp});
    endtask

    // start with preload p, window code w, reaction r; service after n idle cycles
    task automatic svc_trial(input int p, input logic [31:0] w, input logic [3:0] r, input int n);
        int c;
        int thr;
        bit early;
        do_reset();
        cfg_write(2'd0, p);
        cfg_write(2'd1, w);
        cfg_write(2'd2, {28'd0, r});
        pulse_start();
        repeat (n) @(negedge clk);
        key_write(16'hE51A);
        c = p - n - 1;
        thr = p >> exp_shift(w);
        early = (c > thr);
        key_write(16'hA35C);
        chk("R6 early flag", {31'd0, early_flag}, {31'd0, early});
        outcome("R7 reaction", early, r == 4'hA);
        if (!early) chk("R4 R5 reload", count, p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1 reset state
        chk("R1 running", {31'd0, running}, 0);
        chk("R1 count", count, 0);
        chk("R1 flags", {30'd0, early_flag, expire_flag}, 0);
        outcome("R1 requests", 0, 0);

        // R2 start with zero preload ignored
        pulse_start();
        @(negedge clk);
        chk("R2 zero preload start", {31'd0, running}, 0);

        // R2/R3 default reaction expiry, full window
        cfg_write(2'd0, 32'd10);
        pulse_start();
        chk("R2 load", count, 10);
        chk("R2 running", {31'd0, running}, 1);
        repeat (10) @(negedge clk);
        chk("R3 count zero", count, 0);
        chk("R3 not yet expired", {31'd0, expire_flag}, 0);
        @(negedge clk);
        chk("R3 expired", {31'd0, expire_flag}, 1);
        outcome("R7 default reset reaction", 1, 0);
        // R9 sticky, keys ignored
        key_write(16'hE51A); key_write(16'hA35C);
        repeat (5) @(negedge clk);
        outcome("R9 sticky", 1, 0);
        chk("R9 flag sticky", {31'd0, expire_flag}, 1);

        // R7 NMI reaction and invalid code
        svc_trial(40, 32'h5, 4'hA, 45 - 6); // c = 40-39-1 = 0, full window -> ok
        do_reset();
        cfg_write(2'd0, 32'd6); cfg_write(2'd2, 32'hA);
        pulse_start(); repeat (7) @(negedge clk);
        outcome("R7 nmi on expiry", 1, 1);
        do_reset();
        cfg_write(2'd0, 32'd6); cfg_write(2'd2, 32'h3);
        pulse_start(); repeat (7) @(negedge clk);
        outcome("R7 invalid code gives reset", 1, 0);

        // R8 config after start ignored
        do_reset();
        cfg_write(2'd0, 32'd20); cfg_write(2'd1, 32'h50);
        pulse_start();
        cfg_write(2'd0, 32'd5); cfg_write(2'd2, 32'hA); cfg_write(2'd1, 32'h5);
        pulse_start();
        repeat (16) @(negedge clk);        // count = 20 - 20 = 0 after 20 edges total
        chk("R8 count unaffected", count, 0);
        @(negedge clk);
        outcome("R8 reaction locked", 1, 0);

        // R4 wrong second key cancels
        do_reset();
        cfg_write(2'd0, 32'd50);
        pulse_start();
        key_write(16'hE51A); key_write(16'h1234); key_write(16'hA35C);
        chk("R4 no service on wrong key", count, 47);
        chk("R4 no trip", {31'd0, rst_req}, 0);
        key_write(16'hE51A); @(negedge clk); key_write(16'hA35C);
        chk("R4 gap allowed reload", count, 50);

        // R5/R6 threshold boundaries: p=64, 1/4 -> thr=16
        svc_trial(64, 32'h500, 4'h5, 64 - 16 - 1); // c = 16 -> accept
        svc_trial(64, 32'h500, 4'h5, 64 - 17 - 1); // c = 17 -> early
        svc_trial(64, 32'h00500000, 4'hA, 64 - 2 - 1); // c = 2 = thr -> accept
        svc_trial(64, 32'h12345678, 4'hA, 64 - 3 - 1); // c = 3 > 2 -> early

        // random sweep
        for (int i = 0; i < 40; i++) begin
            int p;
            int n;
            logic [31:0] w;
            logic [3:0] r;
            int k;
            p = 16 + ($urandom % 240);
            n = $urandom % (p - 1);
            k = $urandom % 7;
            case (k)
                0: w = 32'h5; 1: w = 32'h50; 2: w = 32'h500; 3: w = 32'h5000;
                4: w = 32'h50000; 5: w = 32'h500000; default: w = $urandom;
            endcase
            r = ($urandom % 3 == 0) ? 4'hA : (($urandom % 2) ? 4'h5 : 4'h7);
            svc_trial(p, w, r, n);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule